// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block turns a virtual address into a physical address by searching a small set of fully associative entries. Each entry holds a virtual word (page tag plus status flags) and a physical word (frame bits plus a page-size exponent), so entries of very different page sizes can sit side by side. Software loads an entry by giving its index and the two words on the write port. A lookup gives a virtual address and a read/write flag. One cycle later the block reports either a hit, with the physical address and the index of the entry that hit, or a miss.

On a miss the block raises a one-cycle translation-fault pulse and keeps the faulting virtual address until the next miss. On a hit it marks the entry as referenced, and also as dirty when the access is a write. A read port shows the current contents of any entry, so that software can collect these flags. Choosing which entry to replace and walking page tables are left to the software that drives the write port.

Top module: `tlb_varpage`

## Requirements
- R1: When more than one entry matches a lookup, the entry with the lowest index is reported.
- R2: The page size of an entry is 2 to the power of bits [4:0] of its physical word. Software uses exponents from 5 to 31.
- R3: An entry hits only when bit 0 (valid) of its virtual word is 1 and the virtual address lies in the range from the virtual word cleared below the page size (inclusive) up to that base plus the page size (exclusive).
- R4: On a miss, res_hit is 0 and res_fault is 1 for exactly that one result cycle. fault_addr takes the missed virtual address and holds it through hits and idle cycles until the next miss.
- R5: A hit sets bit 1 (referenced) of the entry's virtual word. A write hit also sets bit 2 (dirty). A read hit leaves the dirty bit unchanged.
- R6: On a hit, res_paddr is the physical word with all bits below the page size cleared, ORed with those same low bits of the virtual address. res_idx gives the index of the entry that hit.
- R7: A lookup sampled at one clock edge is reported after that edge, with res_valid at 1. A cycle with no lookup gives res_valid, res_hit and res_fault all at 0.
- R8: A write replaces both words of the entry. A lookup in the same cycle still sees the old contents, and a lookup in the next cycle sees the new ones. When a write and a flag update hit the same entry in the same cycle, the written value is kept.
- R9: After reset every entry is all zero, so all entries are invalid, and all result outputs and fault_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 4 | Entry to load |
| wr_vword | input | 32 | Virtual word: tag, valid bit 0, referenced bit 1, dirty bit 2 |
| wr_pword | input | 32 | Physical word: frame bits, size exponent in bits [4:0] |
| rd_idx | input | 4 | Entry shown on the read port |
| rd_vword | output | 32 | Current virtual word of entry rd_idx |
| rd_pword | output | 32 | Current physical word of entry rd_idx |
| res_valid | output | 1 | A result is present |
| res_hit | output | 1 | Result is a hit |
| res_fault | output | 1 | Translation-fault pulse (miss) |
| res_idx | output | 4 | Index of the entry that hit |
| res_paddr | output | 32 | Translated physical address |
| fault_addr | output | 32 | Virtual address of the most recent miss |

## Verification
Every entry gets its own page size, and each one is probed at its base, its last byte, one past its end, one below its base and its middle. These probes show whether the range ends are inclusive or exclusive and whether the offset and frame bits are cut at the right place. An entry whose valid bit is clear sits in the sweep, and an oversized entry placed over a smaller one with a higher index tests the lowest-index rule on the shared addresses and on the addresses only the larger entry covers. Random lookups of both kinds are checked against a model kept in the bench, and the flag words read back afterwards show that dirty follows writes only. Separate tests cover a write in the same cycle as a lookup and a flag update that collides with a write.

// File: rtl/tlb_vp_pkg.sv
package tlb_vp_pkg;
    localparam int BIT_VALID = 0;
    localparam int BIT_REF   = 1;
    localparam int BIT_DIRTY = 2;
endpackage

// File: rtl/tlb_vp_match.sv
module tlb_vp_match #(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic [AW-1:0] vword,
    input  logic [AW-1:0] pword,
    input  logic [AW-1:0] vaddr,
    output logic          hit,
    output logic [AW-1:0] paddr
);
    import tlb_vp_pkg::*;

    logic [SW-1:0] size_exp;
    logic [AW-1:0] off_mask;

    always_comb begin
        size_exp = pword[SW-1:0];
        off_mask = ~({AW{1'b1}} << size_exp);
        // range test: base <= va < base + size, base page-aligned
        hit      = vword[BIT_VALID] && ((vaddr & ~off_mask) == (vword & ~off_mask));
        paddr    = (pword & ~off_mask) | (vaddr & off_mask);
    end
endmodule

// File: rtl/tlb_vp_prio.sv
module tlb_vp_prio #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IW'(i);
                grant = N'(1) << i;
            end
        end
    end

    always_comb begin
        assert (((req == '0) && (grant == '0)) || ((grant & req) != '0)) else $error("p_grant_in_req_r1");
    end
endmodule

// File: rtl/tlb_varpage.sv
module tlb_varpage #(
    parameter int AW = 32,
    parameter int N  = 16,
    parameter int SW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [AW-1:0]        lk_vaddr,
    input  logic                 lk_write,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [AW-1:0]        wr_vword,
    input  logic [AW-1:0]        wr_pword,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [AW-1:0]        rd_vword,
    output logic [AW-1:0]        rd_pword,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic                 res_fault,
    output logic [$clog2(N)-1:0] res_idx,
    output logic [AW-1:0]        res_paddr,
    output logic [AW-1:0]        fault_addr
);
    import tlb_vp_pkg::*;

    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0][AW-1:0] vw;
        logic [N-1:0][AW-1:0] pw;
        logic                 res_valid;
        logic                 res_hit;
        logic                 res_fault;
        logic [IW-1:0]        res_idx;
        logic [AW-1:0]        res_paddr;
        logic [AW-1:0]        fault_addr;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]  ent_hit;
    logic [AW-1:0] ent_paddr [N];
    logic [N-1:0]  grant;
    logic [IW-1:0] hit_idx;
    logic          any_hit;

    for (genvar g = 0; g < N; g++) begin : g_ent
        tlb_vp_match #(.AW(AW), .SW(SW)) u_match (
            .vword (st_q.vw[g]),
            .pword (st_q.pw[g]),
            .vaddr (lk_vaddr),
            .hit   (ent_hit[g]),
            .paddr (ent_paddr[g])
        );
    end

    tlb_vp_prio #(.N(N), .IW(IW)) u_prio (
        .req   (ent_hit),
        .grant (grant),
        .idx   (hit_idx),
        .any   (any_hit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = lk_valid;
        st_d.res_hit   = lk_valid && any_hit;
        st_d.res_fault = lk_valid && !any_hit;
        st_d.res_idx   = (lk_valid && any_hit) ? hit_idx : '0;
        st_d.res_paddr = (lk_valid && any_hit) ? ent_paddr[hit_idx] : '0;
        if (lk_valid && !any_hit) begin
            st_d.fault_addr = lk_vaddr;
        end
        if (lk_valid && any_hit) begin
            st_d.vw[hit_idx][BIT_REF] = 1'b1;
            if (lk_write) begin
                st_d.vw[hit_idx][BIT_DIRTY] = 1'b1;
            end
        end
        // load wins over a flag update on the same entry
        if (wr_en) begin
            st_d.vw[wr_idx] = wr_vword;
            st_d.pw[wr_idx] = wr_pword;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vword   = st_q.vw[rd_idx];
    assign rd_pword   = st_q.pw[rd_idx];
    assign res_valid  = st_q.res_valid;
    assign res_hit    = st_q.res_hit;
    assign res_fault  = st_q.res_fault;
    assign res_idx    = st_q.res_idx;
    assign res_paddr  = st_q.res_paddr;
    assign fault_addr = st_q.fault_addr;

    p_result_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && !res_fault));
    p_fault_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !any_hit) |=> (res_fault && fault_addr == $past(lk_vaddr)));
    p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && !any_hit) |=> $stable(fault_addr));
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_ref_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && any_hit && !(wr_en && wr_idx == hit_idx))
        |=> st_q.vw[$past(hit_idx)][BIT_REF]);
    p_load_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.pw[$past(wr_idx)] == $past(wr_pword)
                   && st_q.vw[$past(wr_idx)] == $past(wr_vword)));
endmodule

// File: tb/tlb_varpage_test.sv
module tlb_varpage_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vword = '0;
    logic [31:0] wr_pword = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_vword, rd_pword, res_paddr, fault_addr;
    logic        res_valid, res_hit, res_fault;
    logic [3:0]  res_idx;

    int total = 0;
    int bad = 0;

    logic [31:0] mvw [N];
    logic [31:0] mpw [N];
    logic [31:0] mfault = '0;

    always #5ns clk = ~clk;

    tlb_varpage uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vword(wr_vword),
        .wr_pword(wr_pword), .rd_idx(rd_idx), .rd_vword(rd_vword), .rd_pword(rd_pword),
        .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
        .res_idx(res_idx), .res_paddr(res_paddr), .fault_addr(fault_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lomask(input logic [31:0] pw);
        return (32'h1 << pw[4:0]) - 32'h1;
    endfunction

    task automatic load(input int idx, input logic [31:0] vw, input logic [31:0] pw);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vword = vw; wr_pword = pw;
        @(negedge clk);
        wr_en = 1'b0;
        mvw[idx] = vw; mpw[idx] = pw;
    endtask

    // one lookup, result compared with the bench model
    task automatic look(input logic [31:0] va, input bit wr, input string req);
        bit hit = 0;
        int hi = 0;
        logic [31:0] lo;
        for (int i = 0; i < N; i++) begin
            lo = lomask(mpw[i]);
            if (!hit && mvw[i][0] && ((va & ~lo) == (mvw[i] & ~lo))) begin
                hit = 1; hi = i;
            end
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        chk(res_valid == 1'b1, {req, " R7 valid"}, 32'(res_valid), 32'h1);
        chk(res_hit == hit, {req, " R3 hit"}, 32'(res_hit), 32'(hit));
        chk(res_fault == !hit, {req, " R4 fault"}, 32'(res_fault), 32'(!hit));
        if (hit) begin
            lo = lomask(mpw[hi]);
            chk(res_idx == 4'(hi), {req, " R1 idx"}, 32'(res_idx), 32'(hi));
            chk(res_paddr == ((mpw[hi] & ~lo) | (va & lo)), {req, " R6 paddr"},
                res_paddr, (mpw[hi] & ~lo) | (va & lo));
            mvw[hi] = mvw[hi] | 32'h2 | (wr ? 32'h4 : 32'h0);
        end else begin
            mfault = va;
        end
        chk(fault_addr == mfault, {req, " R4 fault_addr"}, fault_addr, mfault);
    endtask

    task automatic check_flags(input string req);
        for (int i = 0; i < N; i++) begin
            rd_idx = 4'(i);
            #1ns;
            chk(rd_vword == mvw[i], req, rd_vword, mvw[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mvw[i] = '0; mpw[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!res_valid && !res_hit && !res_fault, "R9 outputs", {29'b0, res_valid, res_hit, res_fault}, 0);
        chk(fault_addr == 0, "R9 fault_addr", fault_addr, 0);
        check_flags("R9 entries zero");

        // R4: empty table misses
        look(32'h1234_5678, 0, "empty");

        // R2/R3/R6: each entry its own size, entry 5 invalid
        for (int i = 0; i < N; i++) begin
            logic [31:0] sz = 32'(12 + (i % 12));
            logic [31:0] pw = ($urandom() & ~32'h1F) | sz;
            load(i, (32'(i) << 24) | ((i == 5) ? 32'h0 : 32'h1), pw);
        end
        for (int i = 0; i < N; i++) begin
            logic [31:0] base = 32'(i) << 24;
            logic [31:0] size = 32'h1 << mpw[i][4:0];
            look(base, 0, "sweep base");
            look(base + size - 1, 1, "sweep last");
            look(base + size, 0, "sweep past end");
            look(base - 1, 1, "sweep below");
            look(base + size / 2, 0, "sweep mid");
        end
        check_flags("R5 flags after sweep");

        // R7: idle cycle
        @(negedge clk);
        chk(!res_valid && !res_hit && !res_fault, "R7 idle", {29'b0, res_valid, res_hit, res_fault}, 0);
        chk(fault_addr == mfault, "R4 hold idle", fault_addr, mfault);

        // R1: entry 9 overlays entry 2 with a bigger page
        load(9, 32'h0200_0001, 32'h4000_0000 | 32'd20);
        look(32'h0200_0010, 0, "R1 low wins");
        look(32'h0200_0000 + (32'h1 << mpw[2][4:0]) + 32'h40, 0, "R1 upper only");

        // R5: fresh entry, read then write
        load(12, 32'h0C00_0001, 32'h7700_0000 | 32'd16);
        look(32'h0C00_0100, 0, "R5 read");
        rd_idx = 4'd12; #1ns;
        chk(rd_vword[2:1] == 2'b01, "R5 ref only", 32'(rd_vword[2:1]), 32'h1);
        look(32'h0C00_0200, 1, "R5 write");
        rd_idx = 4'd12; #1ns;
        chk(rd_vword[2:1] == 2'b11, "R5 dirty", 32'(rd_vword[2:1]), 32'h3);

        // R8: load and lookup in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd10; wr_vword = 32'hA500_0001; wr_pword = 32'h1100_0000 | 32'd12;
        lk_valid = 1'b1; lk_vaddr = 32'hA500_0123; lk_write = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        chk(res_fault && !res_hit, "R8 same cycle old", 32'(res_hit), 0);
        mvw[10] = 32'hA500_0001; mpw[10] = 32'h1100_0000 | 32'd12; mfault = 32'hA500_0123;
        look(32'hA500_0123, 0, "R8 next cycle");

        // R8: load beats flag update of the same entry
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd12; wr_vword = 32'h0C00_0001; wr_pword = 32'h7700_0000 | 32'd16;
        lk_valid = 1'b1; lk_vaddr = 32'h0C00_0004; lk_write = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0; lk_write = 1'b0;
        chk(res_hit && res_idx == 4'd12, "R8 collide hit", 32'(res_idx), 32'd12);
        rd_idx = 4'd12; #1ns;
        chk(rd_vword == 32'h0C00_0001, "R8 load kept", rd_vword, 32'h0C00_0001);
        mvw[12] = 32'h0C00_0001;

        // random mix against the model
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] va = (32'($urandom_range(0, 15)) << 24) | ($urandom() & 32'h00FF_FFFF);
            if (k % 4 == 0) va = va & 32'hFF00_7FFF;
            look(va, 1'($urandom_range(0, 1)), "random R3");
        end
        check_flags("R5 flags after random");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule